// File: doc/BRIEF.md
# Wide Word Slice Serializer

The block takes wide words, each made of several equal-width slices joined together, and sends them out one slice per transfer on a narrow stream. Slices leave most significant first. In the default build a wide word is 96 bits, made of three 32-bit slices.

Both sides use a valid/ready handshake. A small queue in front of the slicer lets the upstream send several wide words before the narrow side has drained the first. A wide word stays at the head of the queue until the narrow side has accepted its last slice. Only then is it released.

Top module: `slice_serializer`

## Requirements
- R1: After reset, out_valid_o is low and in_ready_o is high.
- R2: The slices of a word leave most significant first. The first transfer carries bits [N_SLICES*SLICE_W-1 : (N_SLICES-1)*SLICE_W]. The last transfer carries bits [SLICE_W-1:0].
- R3: The number of narrow transfers equals N_SLICES times the number of accepted wide words. No transfer is added and none is dropped.
- R4: The queue holds DEPTH wide words (16 by default). in_ready_o is high exactly when fewer than DEPTH words are held. An offered word is not written while the queue is full, and no held word is overwritten.
- R5: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_data_o holds its value into the next cycle.
- R6: A word leaves the queue only in the cycle its last slice is accepted. A full queue raises in_ready_o only after such a transfer.
- R7: A word accepted into an empty queue is presented on the narrow side from the next cycle on.
- R8: After the last slice of a word, the next transfer starts the following word again at its most significant slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | A wide word is offered |
| in_data_i | input | N_SLICES*SLICE_W | Offered wide word |
| in_ready_o | output | 1 | The queue has room for a word |
| out_valid_o | output | 1 | A slice is presented |
| out_data_o | output | SLICE_W | Presented slice |
| out_ready_i | input | 1 | The downstream takes the slice |

## Verification
Both handshakes complete on a rising edge. Every effect of a transfer is due exactly one edge later:
- A write into an empty queue shows on out_valid_o and out_data_o after that single edge.
- Taking a final slice raises in_ready_o after that single edge.
- Taking any slice brings the next slice forward after that single edge.

The bench keeps its reference queue of words and its slice index. It updates them on each rising edge from the handshakes it drove there. It compares all outputs at the following falling edge, so each result is checked in the cycle it is due.

// File: rtl/slice_ser_pkg.sv
package slice_ser_pkg;
  // index width that never collapses to zero bits
  function automatic int unsigned idx_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/wide_queue.sv
module wide_queue
  import slice_ser_pkg::*;
#(
  parameter int unsigned WORD_W = 96,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              pop_i,
  output logic [WORD_W-1:0] data_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam int unsigned AW = idx_w(DEPTH);
  localparam int unsigned CW = AW + 1;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     count;
  logic              do_push, do_pop;

  assign empty_o = (count == '0);
  assign full_o  = (count == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem[rd_ptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/slice_counter.sv
module slice_counter
  import slice_ser_pkg::*;
#(
  parameter int unsigned N_SLICES = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        advance_i,
  output logic [idx_w(N_SLICES)-1:0]  cnt_o,
  output logic                        last_o
);
  localparam int unsigned CW = idx_w(N_SLICES);

  assign last_o = (cnt_o == CW'(N_SLICES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_o <= '0;
    else if (advance_i) cnt_o <= last_o ? '0 : cnt_o + 1'b1;
  end
endmodule

// File: rtl/slice_mux.sv
module slice_mux
  import slice_ser_pkg::*;
#(
  parameter int unsigned N_SLICES = 3,
  parameter int unsigned SLICE_W  = 32
) (
  input  logic [N_SLICES*SLICE_W-1:0] word_i,
  input  logic [idx_w(N_SLICES)-1:0]  sel_i,
  output logic [SLICE_W-1:0]          slice_o
);
  logic [SLICE_W-1:0] parts [N_SLICES];

  for (genvar g = 0; g < N_SLICES; g++) begin : g_part
    assign parts[g] = word_i[g*SLICE_W +: SLICE_W];
  end

  assign slice_o = parts[sel_i];
endmodule

// File: rtl/slice_serializer.sv
module slice_serializer
  import slice_ser_pkg::*;
#(
  parameter int unsigned N_SLICES = 3,
  parameter int unsigned SLICE_W  = 32,
  parameter int unsigned DEPTH    = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        in_valid_i,
  input  logic [N_SLICES*SLICE_W-1:0] in_data_i,
  output logic                        in_ready_o,
  output logic                        out_valid_o,
  output logic [SLICE_W-1:0]          out_data_o,
  input  logic                        out_ready_i
);
  localparam int unsigned WORD_W = N_SLICES * SLICE_W;
  localparam int unsigned CW     = idx_w(N_SLICES);

  logic [WORD_W-1:0] head;
  logic              empty, full, fire, last;
  logic [CW-1:0]     cnt, sel;

  assign in_ready_o  = !full;
  assign out_valid_o = !empty;
  assign fire        = out_valid_o && out_ready_i;
  // most significant slice first
  assign sel         = CW'(N_SLICES - 1) - cnt;

  wide_queue #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_queue (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (in_valid_i),
    .data_i  (in_data_i),
    .pop_i   (fire && last),
    .data_o  (head),
    .empty_o (empty),
    .full_o  (full)
  );

  slice_counter #(.N_SLICES(N_SLICES)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .advance_i (fire),
    .cnt_o     (cnt),
    .last_o    (last)
  );

  slice_mux #(.N_SLICES(N_SLICES), .SLICE_W(SLICE_W)) u_mux (
    .word_i  (head),
    .sel_i   (sel),
    .slice_o (out_data_o)
  );
endmodule

// File: rtl/slice_serializer_chk.sv
module slice_serializer_chk #(
  parameter int unsigned N_SLICES = 3,
  parameter int unsigned SLICE_W  = 32,
  parameter int unsigned DEPTH    = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               in_valid_i,
  input logic               in_ready_o,
  input logic               out_valid_o,
  input logic [SLICE_W-1:0] out_data_o,
  input logic               out_ready_i
);
  int unsigned occ, sidx;
  logic in_fire, out_fire, last_fire;

  assign in_fire   = in_valid_i && in_ready_o;
  assign out_fire  = out_valid_o && out_ready_i;
  assign last_fire = out_fire && (sidx == N_SLICES - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ  <= 0;
      sidx <= 0;
    end else begin
      occ <= occ + (in_fire ? 1 : 0) - (last_fire ? 1 : 0);
      if (out_fire) sidx <= (sidx == N_SLICES - 1) ? 0 : sidx + 1;
    end
  end

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ <= DEPTH) && (in_ready_o == (occ < DEPTH)));

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

  assert_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o ##1 in_ready_o |-> $past(last_fire));

  assert_present_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_fire |=> out_valid_o);

  assert_count_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == (occ != 0));
endmodule

bind slice_serializer slice_serializer_chk #(
  .N_SLICES(N_SLICES), .SLICE_W(SLICE_W), .DEPTH(DEPTH)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_data_o  (out_data_o),
  .out_ready_i (out_ready_i)
);

// File: tb/slice_serializer_tb.sv
module slice_serializer_tb;
  localparam int NS = 3;
  localparam int SW = 32;
  localparam int DP = 16;
  localparam int WW = NS * SW;

  logic clk_i = 0, rst_ni = 0;
  logic in_valid_i = 0, out_ready_i = 0;
  logic [WW-1:0] in_data_i = '0;
  logic in_ready_o, out_valid_o;
  logic [SW-1:0] out_data_o;

  int checks = 0, errors = 0;
  int accepted = 0, emitted = 0;
  bit done = 0;
  logic [WW-1:0] mq[$];
  int sidx = 0;
  logic hold_prev = 0;
  logic [SW-1:0] data_prev;

  always #2 clk_i = ~clk_i;

  slice_serializer #(.N_SLICES(NS), .SLICE_W(SW), .DEPTH(DP)) u_dut (
    .clk_i, .rst_ni, .in_valid_i, .in_data_i, .in_ready_o,
    .out_valid_o, .out_data_o, .out_ready_i
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] exp_slice();
    logic [WW-1:0] w = mq[0];
    return w[(NS-1-sidx)*SW +: SW];
  endfunction

  // compare at negedge, drive, then apply model update at posedge
  task automatic step(input int pv, input int pr);
    logic iv, orr, inf, outf;
    @(negedge clk_i);
    chk(mq.size() == DP ? "R6 in_ready" : "R4 in_ready", in_ready_o, mq.size() < DP);
    chk("R7 out_valid", out_valid_o, mq.size() > 0);
    if (mq.size() > 0)
      chk(sidx == 0 ? "R8 first slice" : "R2 slice", out_data_o, exp_slice());
    if (hold_prev) chk("R5 hold", out_data_o, data_prev);
    iv  = ($urandom_range(99) < pv);
    orr = ($urandom_range(99) < pr);
    in_valid_i  = iv;
    in_data_i   = {$urandom, $urandom, $urandom};
    out_ready_i = orr;
    inf  = iv && (mq.size() < DP);
    outf = orr && (mq.size() > 0);
    hold_prev = (mq.size() > 0) && !orr;
    data_prev = out_data_o;
    @(posedge clk_i);
    if (outf) begin
      emitted++;
      if (sidx == NS - 1) begin sidx = 0; void'(mq.pop_front()); end
      else sidx++;
    end
    if (inf) begin mq.push_back(in_data_i); accepted++; end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1;
    chk("R1 out_valid", out_valid_o, 0);
    chk("R1 in_ready", in_ready_o, 1);
    #10 rst_ni = 1;
    // fill past capacity with downstream stalled
    for (int i = 0; i < DP + 6; i++) step(100, 0);
    // slow release while upstream keeps offering
    for (int i = 0; i < 12; i++) step(100, 50);
    for (int i = 0; i < 80; i++) step(0, 100);
    // single word through empty queue
    step(100, 0);
    for (int i = 0; i < 6; i++) step(0, 100);
    for (int i = 0; i < 3000; i++) step(40, 70);
    for (int i = 0; i < 2000; i++) step(80, 30);
    for (int i = 0; i < 3000; i++) step(50, 90);
    for (int i = 0; i < 100; i++) step(0, 100);
    chk("R3 drained", mq.size(), 0);
    chk("R3 transfer count", emitted, accepted * NS);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule